// File: doc/BRIEF.md
# Floating-Point Adder with Round-to-Nearest-Even

This block adds or subtracts two binary floating-point words and returns a correctly rounded result one clock later. Each word has a sign at the most significant bit, a biased exponent below it and a fraction in the low bits. The significand carries an implied leading one. The width of the exponent and fraction fields are parameters, and the defaults give the 32-bit single-precision layout (8-bit exponent, bias 127, 23-bit fraction).

The datapath has four steps in sequence. It aligns the operand with the smaller magnitude by shifting it right while it keeps guard, round and sticky bits. It adds or subtracts the two significands according to their effective signs. A single left shifter, driven by a leading-zero count, normalizes both a carry-out and any depth of cancellation. It then rounds to nearest with ties to even and renormalizes when rounding carries out of the significand. Exponent codes of all zeros and all ones are reserved and take a separate special-case path.

Top module: `fp_add_rne`

## Requirements
- R1: The result and flags are registered. They reflect the inputs present at the previous rising clock edge. A synchronous active-low reset clears the result word and both flags to zero.
- R2: For two normal operands (exponent code 1 to all-ones minus one) the result is the exact sum rounded to nearest with ties to even, packed as sign, exponent, fraction from MSB to LSB.
- R3: When `sub_sel` is 1 the sign of `op_b` is inverted before any other step, so the block computes `op_a - op_b`.
- R4: A nonzero pair of normals whose exact sum is zero gives positive zero (all bits 0) with neither flag set.
- R5: When the rounded exponent reaches the all-ones code, the result is infinity with the sum's sign (exponent all ones, fraction zero) and `ovf` is 1.
- R6: When a nonzero result's exponent falls to zero or below, the result is zero with the sum's sign and `unf` is 1.
- R7: An exponent code of zero marks the operand as zero and its fraction is ignored. Zero plus a normal returns the normal with its effective sign. Zero plus zero is negative zero only when both effective signs are negative, otherwise positive zero. No flag is set.
- R8: An exponent code of all ones marks the operand as infinity and its fraction is ignored. One infinity returns that infinity with its effective sign. Two infinities with the same effective sign return that infinity. Two with opposite signs return the quiet-NaN code: sign 0, exponent all ones, fraction MSB 1 and rest 0. No flag is set.
- R9: `ovf` and `unf` are never 1 together, and each is 1 only with its matching result pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 1+EXP_W+FRAC_W | First operand word |
| op_b | input | 1+EXP_W+FRAC_W | Second operand word |
| sub_sel | input | 1 | 1 selects subtraction of op_b |
| res | output | 1+EXP_W+FRAC_W | Rounded result word |
| ovf | output | 1 | Exponent overflow, result is infinity |
| unf | output | 1 | Exponent underflow, result is signed zero |

## Verification
The bench sweeps a second instance built with a 4-bit exponent and 3-bit fraction over every operand pair in both add and subtract modes. A reference built on exact integer sums, with explicit tie-to-even rounding, checks every output. This sweep covers the paths that are easy to confuse: carry-out with renormalization, one-bit and deep cancellation, rounding ties with even and odd significands, and exact zero against underflow against overflow. It also covers every reserved-exponent combination, including fraction bits that must be ignored. A short set of directed single-precision sums checks the default layout, covering a halfway tie that must round down, exact cancellation and overflow to infinity. The bench also confirms the one-cycle latency and the reset state.

// File: rtl/fpa_pkg.sv
// Shared types for the floating-point adder.
// Assumes: operand words are sign | exponent | fraction, MSB first.
package fpa_pkg;

    // Class of an input operand, decided from its exponent code alone.
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2
    } op_cls_t;

endpackage

// File: rtl/fpa_special.sv
// Special-case path: classifies both operands by exponent code and
// produces the final word when either is zero or infinity.
// Assumes: the sign of op_b is already inverted for subtraction by the
// caller through sub_sel here; fraction bits of reserved codes are ignored.
module fpa_special
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                  sub_sel,
    output logic                  is_special,
    output logic [EXP_W+FRAC_W:0] special_word
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic             sgn_a, sgn_b;
    logic [EXP_W-1:0] exp_a, exp_b;
    op_cls_t          cls_a, cls_b;

    assign sgn_a = op_a[WORD_W-1];
    assign sgn_b = op_b[WORD_W-1] ^ sub_sel;
    assign exp_a = op_a[WORD_W-2 -: EXP_W];
    assign exp_b = op_b[WORD_W-2 -: EXP_W];

    // Decide the class of each operand from its exponent code.
    always_comb begin
        cls_a = CLS_NORM;
        cls_b = CLS_NORM;
        if (exp_a == '0)  cls_a = CLS_ZERO;
        if (&exp_a)       cls_a = CLS_INF;
        if (exp_b == '0)  cls_b = CLS_ZERO;
        if (&exp_b)       cls_b = CLS_INF;
    end

    // Pick the special result by priority: infinities, then zeros.
    always_comb begin
        is_special   = 1'b1;
        special_word = '0;
        if (cls_a == CLS_INF && cls_b == CLS_INF) begin
            if (sgn_a != sgn_b)
                special_word = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
            else
                special_word = {sgn_a, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (cls_a == CLS_INF) begin
            special_word = {sgn_a, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (cls_b == CLS_INF) begin
            special_word = {sgn_b, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (cls_a == CLS_ZERO && cls_b == CLS_ZERO) begin
            special_word = {sgn_a & sgn_b, {(WORD_W-1){1'b0}}};
        end else if (cls_a == CLS_ZERO) begin
            special_word = {sgn_b, op_b[WORD_W-2:0]};
        end else if (cls_b == CLS_ZERO) begin
            special_word = op_a;
        end else begin
            is_special = 1'b0;
        end
    end

endmodule

// File: rtl/fpa_align.sv
// Alignment step: orders the operands by magnitude and shifts the smaller
// significand right by the exponent difference, folding every bit shifted
// past the sticky position into the LSB.
// Assumes: both operands are normal (checked elsewhere).
module fpa_align #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                  sub_sel,
    output logic [EXP_W-1:0]      big_exp,
    output logic [FRAC_W+3:0]     big_ext,
    output logic [FRAC_W+3:0]     small_ext,
    output logic                  big_sign,
    output logic                  eff_sub
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXT_W  = SIG_W + 3;

    logic                  a_ge_b;
    logic [WORD_W-1:0]     big_w, small_w;
    logic                  small_sign;
    logic [EXP_W-1:0]      diff;
    logic [EXT_W-1:0]      small_full, shifted, lost;

    assign a_ge_b = op_a[WORD_W-2:0] >= op_b[WORD_W-2:0];

    // Swap so that the larger magnitude sits on the unshifted side.
    always_comb begin
        if (a_ge_b) begin
            big_w      = op_a;
            small_w    = op_b;
            big_sign   = op_a[WORD_W-1];
            small_sign = op_b[WORD_W-1] ^ sub_sel;
        end else begin
            big_w      = op_b;
            small_w    = op_a;
            big_sign   = op_b[WORD_W-1] ^ sub_sel;
            small_sign = op_a[WORD_W-1];
        end
    end

    assign eff_sub    = big_sign ^ small_sign;
    assign big_exp    = big_w[WORD_W-2 -: EXP_W];
    assign diff       = big_exp - small_w[WORD_W-2 -: EXP_W];
    assign big_ext    = {1'b1, big_w[FRAC_W-1:0], 3'b000};
    assign small_full = {1'b1, small_w[FRAC_W-1:0], 3'b000};

    // Right-shift the smaller significand and keep a sticky trace of lost bits.
    always_comb begin
        shifted = small_full >> diff;
        lost    = small_full & ~({EXT_W{1'b1}} << diff);
        if (int'(diff) >= EXT_W) begin
            small_ext = {{(EXT_W-1){1'b0}}, 1'b1};
        end else begin
            small_ext = {shifted[EXT_W-1:1], shifted[0] | (|lost)};
        end
    end

endmodule

// File: rtl/fpa_addnorm.sv
// Add/subtract and normalize: combines the aligned significands, counts
// leading zeros and left-shifts so the leading one lands in the top bit.
// The same shifter covers carry-out (shift 0) and deep cancellation.
// Assumes: big_ext >= small_ext in magnitude when eff_sub is set.
module fpa_addnorm #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W+3:0]        big_ext,
    input  logic [FRAC_W+3:0]        small_ext,
    input  logic                     eff_sub,
    input  logic [EXP_W-1:0]         big_exp,
    output logic [FRAC_W+4:0]        norm,
    output logic signed [EXP_W+1:0]  norm_exp,
    output logic                     sum_zero
);
    localparam int SUM_W = FRAC_W + 5;
    localparam int LZ_W  = $clog2(SUM_W + 1);
    localparam int EW    = EXP_W + 2;

    logic [SUM_W-1:0] raw;
    logic [LZ_W-1:0]  lz;

    // Magnitude add or subtract of the extended significands.
    always_comb begin
        if (eff_sub) raw = {1'b0, big_ext} - {1'b0, small_ext};
        else         raw = {1'b0, big_ext} + {1'b0, small_ext};
    end

    // Leading-zero count: the highest set bit wins.
    always_comb begin
        lz = LZ_W'(SUM_W);
        for (int i = 0; i < SUM_W; i++) begin
            if (raw[i]) lz = LZ_W'(SUM_W - 1 - i);
        end
    end

    assign sum_zero = (raw == '0);
    assign norm     = raw << lz;
    assign norm_exp = EW'(big_exp) + EW'(1) - EW'(lz);

endmodule

// File: rtl/fpa_round.sv
// Rounding and packing: rounds the normalized value to nearest, ties to
// even, renormalizes on carry-out, then maps the exponent to overflow,
// underflow or a packed normal word.
// Assumes: norm has its leading one in the top bit unless sum_zero is set.
module fpa_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W+4:0]        norm,
    input  logic signed [EXP_W+1:0]  norm_exp,
    input  logic                     sum_zero,
    input  logic                     sign,
    output logic [EXP_W+FRAC_W:0]    word,
    output logic                     ovf,
    output logic                     unf
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int SUM_W = FRAC_W + 5;
    localparam int G_POS = SUM_W - 1 - SIG_W;
    localparam int EW    = EXP_W + 2;
    localparam logic signed [EW-1:0] EXP_TOP = EW'(2**EXP_W - 1);

    logic [SIG_W-1:0]       kept, sig_f;
    logic                   guard, sticky, rnd_up;
    logic [SIG_W:0]         inc;
    logic signed [EW-1:0]   exp_f;

    assign kept   = norm[SUM_W-1 -: SIG_W];
    assign guard  = norm[G_POS];
    assign sticky = |norm[G_POS-1:0];
    assign rnd_up = guard & (sticky | kept[0]);
    assign inc    = {1'b0, kept} + (SIG_W+1)'(rnd_up);

    // Renormalize when the increment carries out of the significand.
    always_comb begin
        if (inc[SIG_W]) begin
            sig_f = inc[SIG_W:1];
            exp_f = norm_exp + EW'(1);
        end else begin
            sig_f = inc[SIG_W-1:0];
            exp_f = norm_exp;
        end
    end

    // Range check on the final exponent and packing of the word.
    always_comb begin
        ovf  = 1'b0;
        unf  = 1'b0;
        word = {sign, exp_f[EXP_W-1:0], sig_f[FRAC_W-1:0]};
        if (sum_zero) begin
            word = '0;
        end else if (exp_f >= EXP_TOP) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf  = 1'b1;
        end else if (exp_f <= 0) begin
            word = {sign, {(EXP_W+FRAC_W){1'b0}}};
            unf  = 1'b1;
        end
    end

endmodule

// File: rtl/fp_add_rne.sv
// Floating-point adder/subtractor, round to nearest even, one register
// stage at the output. Normal operands go through align, add/normalize
// and round; reserved exponent codes take the special-case path.
// Assumes: no subnormal inputs or outputs; synchronous active-low reset.
module fp_add_rne #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                  sub_sel,
    output logic [EXP_W+FRAC_W:0] res,
    output logic                  ovf,
    output logic                  unf
);
    logic                    spc_hit;
    logic [EXP_W+FRAC_W:0]   spc_word;
    logic [EXP_W-1:0]        al_exp;
    logic [FRAC_W+3:0]       al_big, al_small;
    logic                    al_sign, al_sub;
    logic [FRAC_W+4:0]       nm_val;
    logic signed [EXP_W+1:0] nm_exp;
    logic                    nm_zero;
    logic [EXP_W+FRAC_W:0]   rd_word;
    logic                    rd_ovf, rd_unf;

    fpa_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_special (
        .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
        .is_special(spc_hit), .special_word(spc_word)
    );

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
        .big_exp(al_exp), .big_ext(al_big), .small_ext(al_small),
        .big_sign(al_sign), .eff_sub(al_sub)
    );

    fpa_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addnorm (
        .big_ext(al_big), .small_ext(al_small), .eff_sub(al_sub),
        .big_exp(al_exp), .norm(nm_val), .norm_exp(nm_exp), .sum_zero(nm_zero)
    );

    fpa_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .norm(nm_val), .norm_exp(nm_exp), .sum_zero(nm_zero), .sign(al_sign),
        .word(rd_word), .ovf(rd_ovf), .unf(rd_unf)
    );

    // Output register: select special or rounded result, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            res <= spc_hit ? spc_word : rd_word;
            ovf <= !spc_hit && rd_ovf;
            unf <= !spc_hit && rd_unf;
        end
    end

endmodule

// Checker bound to the adder: relates the registered outputs to the
// inputs of the previous cycle for the flag, reserved-code and latency rules.
module fp_add_rne_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [EXP_W+FRAC_W:0] op_a,
    input logic [EXP_W+FRAC_W:0] op_b,
    input logic                  sub_sel,
    input logic [EXP_W+FRAC_W:0] res,
    input logic                  ovf,
    input logic                  unf
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic a_zero, a_inf, b_norm, b_inf;
    assign a_zero = op_a[WORD_W-2 -: EXP_W] == '0;
    assign a_inf  = &op_a[WORD_W-2 -: EXP_W];
    assign b_inf  = &op_b[WORD_W-2 -: EXP_W];
    assign b_norm = (op_b[WORD_W-2 -: EXP_W] != '0) && !b_inf;

    // R5
    ovf_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (&res[WORD_W-2 -: EXP_W]) && (res[FRAC_W-1:0] == '0));

    // R6
    unf_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (res[WORD_W-2:0] == '0));

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(op_a) && $stable(op_b) && $stable(sub_sel))
        |=> $stable(res));

    // R7
    zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_zero && b_norm) |=>
        (res == {$past(op_b[WORD_W-1] ^ sub_sel), $past(op_b[WORD_W-2:0])}) && !ovf && !unf);

    // R8
    inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_inf && !b_inf) |=>
        (res == {$past(op_a[WORD_W-1]), {EXP_W{1'b1}}, {FRAC_W{1'b0}}}) && !ovf && !unf);

endmodule

bind fp_add_rne fp_add_rne_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
    .res(res), .ovf(ovf), .unf(unf)
);

// File: tb/sim_fp_add_rne.sv
`timescale 1ns/1ps
module sim_fp_add_rne;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Default single-precision instance.
    logic [31:0] a0 = '0, b0 = '0, r0;
    logic        s0 = 1'b0, o0, u0f;
    fp_add_rne u0 (.clk(clk), .rst_n(rst_n), .op_a(a0), .op_b(b0), .sub_sel(s0),
                   .res(r0), .ovf(o0), .unf(u0f));

    // Small instance for the exhaustive sweep: 4-bit exponent, 3-bit fraction.
    logic [7:0] a1 = '0, b1 = '0, r1;
    logic       s1 = 1'b0, o1, u1f;
    fp_add_rne #(.EXP_W(4), .FRAC_W(3)) u1 (.clk(clk), .rst_n(rst_n), .op_a(a1),
                   .op_b(b1), .sub_sel(s1), .res(r1), .ovf(o1), .unf(u1f));

    // Reference for the small format: {ovf, unf, word}, exact integer sums in
    // units of 2^-9 (the value of the smallest normal's lowest fraction step).
    function automatic logic [9:0] ref_small(input logic [7:0] a, input logic [7:0] b,
                                             input logic s);
        int ea, eb, va, vb, tot, mag, p, sh, sig, rem, half, ex;
        logic sa, sb, sr;
        ea = int'(a[6:3]); eb = int'(b[6:3]);
        sa = a[7]; sb = b[7] ^ s;
        if (ea == 15 && eb == 15)
            return (sa != sb) ? 10'b00_0_1111_100 : {2'b00, sa, 7'b1111_000};
        if (ea == 15) return {2'b00, sa, 7'b1111_000};
        if (eb == 15) return {2'b00, sb, 7'b1111_000};
        if (ea == 0 && eb == 0) return {2'b00, sa & sb, 7'b0};
        if (ea == 0) return {2'b00, sb, b[6:0]};
        if (eb == 0) return {2'b00, a};
        va = (8 + int'(a[2:0])) << (ea - 1);
        vb = (8 + int'(b[2:0])) << (eb - 1);
        if (sa) va = -va;
        if (sb) vb = -vb;
        tot = va + vb;
        if (tot == 0) return 10'b0;
        sr  = (tot < 0);
        mag = sr ? -tot : tot;
        p = 0;
        for (int i = 0; i < 20; i++) if (((mag >> i) & 1) != 0) p = i;
        if (p < 3) return {2'b01, sr, 7'b0};
        sh  = p - 3;
        sig = mag >> sh;
        rem = mag - (sig << sh);
        if (sh > 0) begin
            half = 1 << (sh - 1);
            if (rem > half || (rem == half && (sig % 2) == 1)) sig++;
        end
        if (sig == 16) begin sig = 8; p++; end
        ex = p - 2;
        if (ex >= 15) return {2'b10, sr, 7'b1111_000};
        return {2'b00, sr, 4'(ex), 3'(sig - 8)};
    endfunction

    function automatic string tag_small(input logic [7:0] a, input logic [7:0] b,
                                        input logic s, input logic [9:0] e);
        if (&a[6:3] || &b[6:3])        return "R8";
        if (a[6:3] == 0 || b[6:3] == 0) return "R7";
        if (e[9])                       return "R5";
        if (e[8])                       return "R6";
        if (e[7:0] == 0)                return "R4";
        if (s)                          return "R3";
        return "R2";
    endfunction

    task automatic chk32(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic [31:0] ew, input logic eo, input logic eu,
                         input string req);
        a0 = a; b0 = b; s0 = s;
        @(negedge clk);
        checks++;
        if (r0 !== ew || o0 !== eo || u0f !== eu) begin
            fails++;
            $display("FAIL %s: res=%h ovf=%b unf=%b expected res=%h ovf=%b unf=%b",
                     req, r0, o0, u0f, ew, eo, eu);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [9:0] exp_s;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (r0 !== '0 || o0 !== 1'b0 || u0f !== 1'b0 || r1 !== '0 || o1 !== 1'b0 || u1f !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: res=%h/%h flags=%b%b/%b%b expected all zero", r0, r1, o0, u0f, o1, u1f);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1: output holds until the next rising edge
        a0 = 32'h3F80_0000; b0 = 32'h3F80_0000; s0 = 1'b0;
        #2;
        checks++;
        if (r0 !== 32'h0) begin
            fails++;
            $display("FAIL R1 latency: res=%h expected %h before edge", r0, 32'h0);
        end
        @(negedge clk);
        checks++;
        if (r0 !== 32'h4000_0000) begin
            fails++;
            $display("FAIL R1 latency: res=%h expected %h after edge", r0, 32'h4000_0000);
        end

        // Directed single-precision cases.
        chk32(32'h4140_0000, 32'h3F40_0000, 1'b0, 32'h414C_0000, 1'b0, 1'b0, "R2");
        chk32(32'h3F00_0000, 32'hBEE0_0000, 1'b0, 32'h3D80_0000, 1'b0, 1'b0, "R2");
        chk32(32'h3F80_0000, 32'h3380_0000, 1'b0, 32'h3F80_0000, 1'b0, 1'b0, "R2");
        chk32(32'h3F80_0000, 32'hB380_0000, 1'b1, 32'h3F80_0000, 1'b0, 1'b0, "R3");
        chk32(32'h3F80_0000, 32'h3F80_0000, 1'b1, 32'h0000_0000, 1'b0, 1'b0, "R4");
        chk32(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 32'h7F80_0000, 1'b1, 1'b0, "R5");
        chk32(32'h0012_3456, 32'hC040_0000, 1'b0, 32'hC040_0000, 1'b0, 1'b0, "R7");
        chk32(32'h7F80_0001, 32'h7F80_0000, 1'b1, 32'h7FC0_0000, 1'b0, 1'b0, "R8");

        // Exhaustive sweep of the small format.
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                for (int is = 0; is < 2; is++) begin
                    a1 = 8'(ia); b1 = 8'(ib); s1 = is[0];
                    @(negedge clk);
                    exp_s = ref_small(8'(ia), 8'(ib), is[0]);
                    checks++;
                    if ({o1, u1f, r1} !== exp_s) begin
                        fails++;
                        $display("FAIL %s: a=%h b=%h sub=%0d got ovf=%b unf=%b res=%h expected ovf=%b unf=%b res=%h",
                                 tag_small(8'(ia), 8'(ib), is[0], exp_s), ia, ib, is,
                                 o1, u1f, r1, exp_s[9], exp_s[8], exp_s[7:0]);
                    end
                end
            end
        end
        // R6 and R9 are covered inside the sweep; one named spot check each.
        a1 = 8'h09; b1 = 8'h08; s1 = 1'b1;
        @(negedge clk);
        checks++;
        if (r1 !== 8'h00 || u1f !== 1'b1 || o1 !== 1'b0) begin
            fails++;
            $display("FAIL R6/R9: res=%h unf=%b ovf=%b expected res=00 unf=1 ovf=0", r1, u1f, o1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule